// File: doc/BRIEF.md
# Early-Indexed Physically Tagged L1 Data Cache Lookup

This block performs the lookup half of a level-one data cache that holds 64 sets of 8 ways with 64-byte lines. Every bit that picks a set or a word in a line lies inside the 12-bit page offset. That offset is identical before and after address translation, so the block reads the chosen set as soon as the untranslated offset is known. This overlaps the array read with the translation lookaside buffer search.

The requester presents the page offset first. All 8 ways of the addressed set (tag, valid bit and the addressed 64-bit word) are captured into holding registers on that clock edge. In the same cycle that the translation result arrives, or any cycle after it, the 40-bit physical page number is compared with the 8 captured tags. A registered response then reports hit, way and data. A translation fault cancels the lookup. A narrow install port writes tag, valid bit and one data word into a chosen set and way, so that an external refill engine (not part of this block) can fill the array.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After reset every line is invalid and all response outputs are 0. A lookup made before any install reports a miss, even for page number 0.
- R2: Offset bits [11:6] select the set and bits [5:3] select the 64-bit word within the line. Bits [2:0] have no effect. No translated bit takes part in set selection.
- R3: The set is read on the clock edge that ends the cycle in which `va_valid` is high. The translation may arrive in the very next cycle or any number of cycles later. The response is registered and appears in the cycle after `xlat_valid`.
- R4: If exactly one valid way of the captured set has a tag equal to `xlat_ppn`, the block reports `resp_valid`=1, `resp_hit`=1, `resp_way` set to that way number and `resp_data` set to the stored word. The response lasts a single cycle.
- R5: If no valid captured tag equals all 40 bits of `xlat_ppn`, the block reports `resp_valid`=1 and `resp_hit`=0. Whenever no hit is reported, `resp_way` and `resp_data` are 0.
- R6: When `xlat_valid` and `xlat_fault` are both high, no response is produced and the pending lookup is discarded. A later translation without a new offset then produces nothing.
- R7: A new offset presented while a lookup waits for translation replaces it. The next translation is answered against the newer set.
- R8: A translation that arrives with no lookup pending produces no response. Each lookup is answered at most once.
- R9: `inst_en` writes `inst_tag`, `inst_valid` and word `inst_wsel` of `inst_word` into the entry (`inst_set`, `inst_way`). Writing `inst_valid`=0 makes that way miss.
- R10: When a translation and a new offset arrive in the same cycle, the translation completes the older lookup and the new offset becomes the pending one.
- R11: A lookup compares against the set contents captured when its offset was presented. An install made after that point is not visible to that lookup.
- R12: At most one valid way of a set matches a given page number. The install port must not place two valid copies of one tag in one set. Way 7, the highest way, is reported correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| va_valid | input | 1 | Untranslated page offset is presented |
| va_offset | input | 12 | Page offset: set index, word select, byte bits |
| xlat_valid | input | 1 | Translation result is presented |
| xlat_ppn | input | 40 | Physical page number used as the tag |
| xlat_fault | input | 1 | Translation failed; cancels the pending lookup |
| inst_en | input | 1 | Install write strobe |
| inst_set | input | 6 | Set written by the install |
| inst_way | input | 3 | Way written by the install |
| inst_valid | input | 1 | Valid bit written by the install |
| inst_tag | input | 40 | Tag written by the install |
| inst_wsel | input | 3 | Word within the line written by the install |
| inst_word | input | 64 | Data word written by the install |
| resp_valid | output | 1 | A lookup completed this cycle |
| resp_hit | output | 1 | The completed lookup hit |
| resp_way | output | 3 | Way that hit, 0 otherwise |
| resp_data | output | 64 | Word read on a hit, 0 otherwise |

## Verification
Assertions check on every cycle that at most one captured way matches the page number and that a response follows only a non-faulting translation of a pending lookup. They also check that a fault or an orphan translation is silent in the next cycle and that a miss never carries a way or data value. Only the directed scenarios can show the ordering behaviour: replacement by a newer offset, a translation and an offset in the same cycle, and the snapshot effect of an install made after the offset. The scenarios also show that the stored word, the way number and the byte bits that are ignored match what was installed.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    localparam int CFG_SETS       = 64;
    localparam int CFG_WAYS       = 8;
    localparam int CFG_LINE_BYTES = 64;
    localparam int CFG_WORD_BYTES = 8;
    localparam int CFG_PAGE_BITS  = 12;
    localparam int CFG_PPN_W      = 40;

    typedef enum logic {
        LK_IDLE = 1'b0,
        LK_WAIT = 1'b1
    } lk_state_e;

    // Position of the lowest set bit; 0 when the vector is empty.
    function automatic int unsigned onehot_index(input logic [31:0] vec);
        int unsigned idx;
        idx = 0;
        for (int i = 31; i >= 0; i--) begin
            if (vec[i]) idx = i;
        end
        return idx;
    endfunction

endpackage

// File: rtl/vipt_set_store.sv
module vipt_set_store #(
    parameter int SETS   = vipt_pkg::CFG_SETS,
    parameter int WAYS   = vipt_pkg::CFG_WAYS,
    parameter int WORDS  = vipt_pkg::CFG_LINE_BYTES / vipt_pkg::CFG_WORD_BYTES,
    parameter int WORD_W = vipt_pkg::CFG_WORD_BYTES * 8,
    parameter int PPN_W  = vipt_pkg::CFG_PPN_W,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int WSEL_W = $clog2(WORDS)
) (
    input  logic                     clk,
    input  logic                     rst,
    // early read of one set
    input  logic                     rd_en,
    input  logic [IDX_W-1:0]         rd_set,
    input  logic [WSEL_W-1:0]        rd_wsel,
    // install write of one entry
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_set,
    input  logic [WAY_W-1:0]         wr_way,
    input  logic                     wr_valid,
    input  logic [PPN_W-1:0]         wr_tag,
    input  logic [WSEL_W-1:0]        wr_wsel,
    input  logic [WORD_W-1:0]        wr_word,
    // holding registers
    output logic [WAYS*PPN_W-1:0]    hold_tags,
    output logic [WAYS-1:0]          hold_vld,
    output logic [WAYS*WORD_W-1:0]   hold_words
);

    localparam int ENTRIES = SETS * WAYS;
    localparam int LINE_W  = WORDS * WORD_W;
    localparam int ENT_W   = IDX_W + WAY_W;

    logic [ENTRIES-1:0] vld_q;
    logic [PPN_W-1:0]   tag_q  [ENTRIES];
    logic [LINE_W-1:0]  data_q [ENTRIES];

    logic [ENT_W-1:0] wr_idx;
    assign wr_idx = {wr_set, wr_way};

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            data_q[wr_idx][int'(wr_wsel)*WORD_W +: WORD_W] <= wr_word;
        end
    end

    // Capture every way of the addressed set; old contents win on a
    // same-cycle install to the same entry.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_vld   <= '0;
            hold_tags  <= '0;
            hold_words <= '0;
        end else if (rd_en) begin
            for (int w = 0; w < WAYS; w++) begin
                hold_vld[w]                    <= vld_q[{rd_set, WAY_W'(w)}];
                hold_tags[w*PPN_W +: PPN_W]    <= tag_q[{rd_set, WAY_W'(w)}];
                hold_words[w*WORD_W +: WORD_W] <=
                    data_q[{rd_set, WAY_W'(w)}][int'(rd_wsel)*WORD_W +: WORD_W];
            end
        end
    end

endmodule

// File: rtl/vipt_tag_match.sv
module vipt_tag_match #(
    parameter int WAYS  = vipt_pkg::CFG_WAYS,
    parameter int PPN_W = vipt_pkg::CFG_PPN_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WAYS*PPN_W-1:0] hold_tags,
    input  logic [WAYS-1:0]       hold_vld,
    input  logic [PPN_W-1:0]      ppn,
    output logic [WAYS-1:0]       match
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match[w] = hold_vld[w] && (hold_tags[w*PPN_W +: PPN_W] == ppn);
    end

    AST_ONE_WAY_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match)); // R12

endmodule

// File: rtl/vipt_lookup_ctrl.sv
module vipt_lookup_ctrl #(
    parameter int WAYS   = vipt_pkg::CFG_WAYS,
    parameter int WORD_W = vipt_pkg::CFG_WORD_BYTES * 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   va_valid,
    input  logic                   xlat_valid,
    input  logic                   xlat_fault,
    input  logic [WAYS-1:0]        match,
    input  logic [WAYS*WORD_W-1:0] hold_words,
    output logic                   resp_valid,
    output logic                   resp_hit,
    output logic [WAY_W-1:0]       resp_way,
    output logic [WORD_W-1:0]      resp_data
);
    import vipt_pkg::*;

    lk_state_e state_q, state_d;

    logic              complete;
    logic              any_hit;
    logic [WAY_W-1:0]  hit_way;
    logic [WORD_W-1:0] hit_word;

    // a new offset always becomes the pending lookup, any translation
    // retires the one that was pending at the start of the cycle
    always_comb begin
        state_d = state_q;
        if (va_valid)        state_d = LK_WAIT;
        else if (xlat_valid) state_d = LK_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LK_IDLE;
        else     state_q <= state_d;
    end

    assign complete = xlat_valid && !xlat_fault && (state_q == LK_WAIT);
    assign any_hit  = |match;
    assign hit_way  = WAY_W'(onehot_index(32'(match)));

    // AND-OR select, valid because the match vector is one-hot or empty
    always_comb begin
        hit_word = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_word = hit_word | hold_words[w*WORD_W +: WORD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_way   <= '0;
            resp_data  <= '0;
        end else begin
            resp_valid <= complete;
            resp_hit   <= complete && any_hit;
            resp_way   <= (complete && any_hit) ? hit_way  : '0;
            resp_data  <= (complete && any_hit) ? hit_word : '0;
        end
    end

    AST_RESP_AFTER_XLAT: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ($past(xlat_valid) && !$past(xlat_fault))); // R3
    AST_HIT_IS_VALID: assert property (@(posedge clk) disable iff (rst)
        resp_hit |-> resp_valid); // R4
    AST_MISS_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !resp_hit |-> (resp_way == '0 && resp_data == '0)); // R5
    AST_FAULT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (xlat_valid && xlat_fault) |=> !resp_valid); // R6
    AST_ORPHAN_SILENT: assert property (@(posedge clk) disable iff (rst)
        (xlat_valid && state_q == LK_IDLE) |=> !resp_valid); // R8

endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup #(
    parameter int SETS       = vipt_pkg::CFG_SETS,
    parameter int WAYS       = vipt_pkg::CFG_WAYS,
    parameter int LINE_BYTES = vipt_pkg::CFG_LINE_BYTES,
    parameter int WORD_BYTES = vipt_pkg::CFG_WORD_BYTES,
    parameter int PAGE_BITS  = vipt_pkg::CFG_PAGE_BITS,
    parameter int PPN_W      = vipt_pkg::CFG_PPN_W,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int BSEL_W = $clog2(WORD_BYTES),
    localparam int WSEL_W = OFF_W - BSEL_W,
    localparam int WORD_W = WORD_BYTES * 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 va_valid,
    input  logic [PAGE_BITS-1:0] va_offset,
    input  logic                 xlat_valid,
    input  logic [PPN_W-1:0]     xlat_ppn,
    input  logic                 xlat_fault,
    input  logic                 inst_en,
    input  logic [IDX_W-1:0]     inst_set,
    input  logic [WAY_W-1:0]     inst_way,
    input  logic                 inst_valid,
    input  logic [PPN_W-1:0]     inst_tag,
    input  logic [WSEL_W-1:0]    inst_wsel,
    input  logic [WORD_W-1:0]    inst_word,
    output logic                 resp_valid,
    output logic                 resp_hit,
    output logic [WAY_W-1:0]     resp_way,
    output logic [WORD_W-1:0]    resp_data
);

    // early indexing is only legal when index and line offset fit in the page
    if (IDX_W + OFF_W != PAGE_BITS) begin : g_size_check
        $error("set index and line offset must exactly fill the page offset");
    end

    logic [IDX_W-1:0]        rd_set;
    logic [WSEL_W-1:0]       rd_wsel;
    logic                    byte_bits_unused;
    logic [WAYS*PPN_W-1:0]   hold_tags;
    logic [WAYS-1:0]         hold_vld;
    logic [WAYS*WORD_W-1:0]  hold_words;
    logic [WAYS-1:0]         match;

    assign rd_set           = va_offset[OFF_W +: IDX_W];
    assign rd_wsel          = va_offset[BSEL_W +: WSEL_W];
    assign byte_bits_unused = ^va_offset[BSEL_W-1:0];

    vipt_set_store #(
        .SETS(SETS), .WAYS(WAYS), .WORDS(LINE_BYTES / WORD_BYTES),
        .WORD_W(WORD_W), .PPN_W(PPN_W)
    ) u_store (
        .clk(clk), .rst(rst),
        .rd_en(va_valid), .rd_set(rd_set), .rd_wsel(rd_wsel),
        .wr_en(inst_en), .wr_set(inst_set), .wr_way(inst_way),
        .wr_valid(inst_valid), .wr_tag(inst_tag), .wr_wsel(inst_wsel),
        .wr_word(inst_word),
        .hold_tags(hold_tags), .hold_vld(hold_vld), .hold_words(hold_words)
    );

    vipt_tag_match #(.WAYS(WAYS), .PPN_W(PPN_W)) u_match (
        .clk(clk), .rst(rst),
        .hold_tags(hold_tags), .hold_vld(hold_vld), .ppn(xlat_ppn),
        .match(match)
    );

    vipt_lookup_ctrl #(.WAYS(WAYS), .WORD_W(WORD_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .va_valid(va_valid), .xlat_valid(xlat_valid), .xlat_fault(xlat_fault),
        .match(match), .hold_words(hold_words),
        .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_way(resp_way), .resp_data(resp_data)
    );

endmodule

// File: tb/test_vipt_l1_lookup.sv
`timescale 1ns/1ps
module test_vipt_l1_lookup;

    logic        clk = 1'b0;
    logic        rst;
    logic        va_valid;
    logic [11:0] va_offset;
    logic        xlat_valid;
    logic [39:0] xlat_ppn;
    logic        xlat_fault;
    logic        inst_en;
    logic [5:0]  inst_set;
    logic [2:0]  inst_way;
    logic        inst_valid;
    logic [39:0] inst_tag;
    logic [2:0]  inst_wsel;
    logic [63:0] inst_word;
    logic        resp_valid;
    logic        resp_hit;
    logic [2:0]  resp_way;
    logic [63:0] resp_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [39:0] T1 = 40'h12_3456_789A;
    localparam logic [39:0] T2 = 40'h0A_BCDE_F012;
    localparam logic [39:0] T3 = 40'h00_0000_0001;
    localparam logic [39:0] TS = 40'hFF_0000_5555;
    localparam logic [63:0] D1 = 64'hA1A1_0000_0000_0F25;
    localparam logic [63:0] D2 = 64'hB2B2_1111_2222_3F77;
    localparam logic [63:0] D3 = 64'hC3C3_4444_5555_2100;
    localparam logic [63:0] D4 = 64'hD4D4_6666_7777_0541;

    always #2 clk = ~clk;

    vipt_l1_lookup i_vipt_l1_lookup (
        .clk(clk), .rst(rst),
        .va_valid(va_valid), .va_offset(va_offset),
        .xlat_valid(xlat_valid), .xlat_ppn(xlat_ppn), .xlat_fault(xlat_fault),
        .inst_en(inst_en), .inst_set(inst_set), .inst_way(inst_way),
        .inst_valid(inst_valid), .inst_tag(inst_tag), .inst_wsel(inst_wsel),
        .inst_word(inst_word),
        .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_way(resp_way), .resp_data(resp_data)
    );

    function automatic logic [11:0] mk_off(input logic [5:0] set,
                                           input logic [2:0] wsel,
                                           input logic [2:0] bsel);
        return {set, wsel, bsel};
    endfunction

    task automatic check_resp(input string req, input bit ev, input bit eh,
                              input logic [2:0] ew, input logic [63:0] ed);
        checks++;
        if (resp_valid !== ev || resp_hit !== eh || resp_way !== ew || resp_data !== ed) begin
            fails++;
            $display("FAIL %s: got v=%0b h=%0b way=%0d data=%h, expected v=%0b h=%0b way=%0d data=%h",
                     req, resp_valid, resp_hit, resp_way, resp_data, ev, eh, ew, ed);
        end
    endtask

    task automatic install(input logic [5:0] set, input logic [2:0] way, input bit v,
                           input logic [39:0] tag, input logic [2:0] wsel,
                           input logic [63:0] word);
        inst_en = 1'b1; inst_set = set; inst_way = way; inst_valid = v;
        inst_tag = tag; inst_wsel = wsel; inst_word = word;
        @(negedge clk);
        inst_en = 1'b0;
    endtask

    task automatic present(input logic [11:0] off);
        va_valid = 1'b1; va_offset = off;
        @(negedge clk);
        va_valid = 1'b0;
    endtask

    task automatic translate(input logic [39:0] ppn, input bit fault);
        xlat_valid = 1'b1; xlat_ppn = ppn; xlat_fault = fault;
        @(negedge clk);
        xlat_valid = 1'b0; xlat_fault = 1'b0;
    endtask

    task automatic lookup(input logic [11:0] off, input logic [39:0] ppn, input int gap);
        present(off);
        repeat (gap) @(negedge clk);
        translate(ppn, 1'b0);
    endtask

    task automatic t_reset();
        check_resp("R1 idle after reset", 0, 0, 0, 0);
        lookup(mk_off(6'h00, 3'd0, 3'd0), 40'h0, 0);
        check_resp("R1 empty cache misses", 1, 0, 0, 0);
    endtask

    task automatic t_hit();
        install(6'h0F, 3'd2, 1'b1, T1, 3'd5, D1);
        lookup(mk_off(6'h0F, 3'd5, 3'd3), T1, 0);
        check_resp("R4 hit way 2 / R2 byte bits ignored", 1, 1, 3'd2, D1);
        @(negedge clk);
        check_resp("R4 response lasts one cycle", 0, 0, 0, 0);
        lookup(mk_off(6'h0F, 3'd5, 3'd6), T1, 4);
        check_resp("R3 late translation still hits", 1, 1, 3'd2, D1);
    endtask

    task automatic t_way7();
        install(6'h3F, 3'd7, 1'b1, T2, 3'd7, D2);
        lookup(mk_off(6'h3F, 3'd7, 3'd0), T2, 1);
        check_resp("R12 top way reported", 1, 1, 3'd7, D2);
    endtask

    task automatic t_miss();
        lookup(mk_off(6'h0F, 3'd5, 3'd0), T1 ^ 40'h80_0000_0000, 0);
        check_resp("R5 tag differing in bit 39 misses", 1, 0, 0, 0);
        lookup(mk_off(6'h0F, 3'd5, 3'd0), T2, 0);
        check_resp("R2 tag of another set misses", 1, 0, 0, 0);
    endtask

    task automatic t_fault();
        present(mk_off(6'h0F, 3'd5, 3'd0));
        translate(T1, 1'b1);
        check_resp("R6 fault suppresses response", 0, 0, 0, 0);
        translate(T1, 1'b0);
        check_resp("R6 faulted lookup discarded", 0, 0, 0, 0);
    endtask

    task automatic t_replace();
        present(mk_off(6'h0F, 3'd5, 3'd0));
        present(mk_off(6'h3F, 3'd7, 3'd0));
        translate(T2, 1'b0);
        check_resp("R7 newer offset answered", 1, 1, 3'd7, D2);
        present(mk_off(6'h3F, 3'd7, 3'd0));
        present(mk_off(6'h0F, 3'd5, 3'd0));
        translate(T2, 1'b0);
        check_resp("R7 older set no longer compared", 1, 0, 0, 0);
    endtask

    task automatic t_orphan();
        lookup(mk_off(6'h0F, 3'd5, 3'd0), T1, 0);
        check_resp("R8 baseline hit", 1, 1, 3'd2, D1);
        translate(T1, 1'b0);
        check_resp("R8 second translation ignored", 0, 0, 0, 0);
    endtask

    task automatic t_same_cycle();
        install(6'h21, 3'd0, 1'b1, T3, 3'd0, D3);
        present(mk_off(6'h21, 3'd0, 3'd0));
        va_valid = 1'b1; va_offset = mk_off(6'h0F, 3'd5, 3'd0);
        xlat_valid = 1'b1; xlat_ppn = T3; xlat_fault = 1'b0;
        @(negedge clk);
        va_valid = 1'b0; xlat_valid = 1'b0;
        check_resp("R10 translation completes older lookup", 1, 1, 3'd0, D3);
        translate(T1, 1'b0);
        check_resp("R10 new offset left pending", 1, 1, 3'd2, D1);
    endtask

    task automatic t_snapshot();
        present(mk_off(6'h05, 3'd1, 3'd0));
        install(6'h05, 3'd4, 1'b1, TS, 3'd1, D4);
        translate(TS, 1'b0);
        check_resp("R11 later install not visible", 1, 0, 0, 0);
        lookup(mk_off(6'h05, 3'd1, 3'd0), TS, 0);
        check_resp("R9 installed line hits", 1, 1, 3'd4, D4);
    endtask

    task automatic t_invalidate();
        install(6'h3F, 3'd7, 1'b0, T2, 3'd7, D2);
        lookup(mk_off(6'h3F, 3'd7, 3'd0), T2, 0);
        check_resp("R9 invalidated way misses", 1, 0, 0, 0);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got no completion, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; va_valid = 1'b0; va_offset = '0; xlat_valid = 1'b0;
        xlat_ppn = '0; xlat_fault = 1'b0; inst_en = 1'b0; inst_set = '0;
        inst_way = '0; inst_valid = 1'b0; inst_tag = '0; inst_wsel = '0;
        inst_word = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_hit();
        t_way7();
        t_miss();
        t_fault();
        t_replace();
        t_orphan();
        t_same_cycle();
        t_snapshot();
        t_invalidate();
        done = 1;
        summary();
        $finish;
    end

endmodule